// File: doc/BRIEF.md
# Dual-Tone Frequency Counting Detector

This block recognises a two-tone keypad signal from two limited square waves. One wave carries the low-band tone and the other carries the high-band tone. Each wave has its own tracker. A tracker counts reference-clock cycles between successive rising edges. It keeps the last four period counts in a sliding window and compares their sum against a window for each of the four nominal tones of its band. When both bands hold exactly one matching tone, a registered early-valid flag rises, and the band indices are presented beside it. The flag only means that the frequencies are right. Checking that the tone lasts long enough is left to a separate steering stage.

Each tracker is a three-state machine:
- TRK_IDLE waits for a first rising edge and then moves to TRK_FILL.
- TRK_FILL gathers periods that lie inside the band's coarse range. When it has four, it moves to TRK_LOCK.
- TRK_LOCK keeps sliding the window and matching the sum against the tone windows.
- From TRK_FILL or TRK_LOCK, a period outside the coarse range restarts TRK_FILL with an empty window.
- From TRK_FILL or TRK_LOCK, a period counter that runs past the coarse range (the input has gone quiet) returns the tracker to TRK_IDLE.
- Power-down forces TRK_IDLE from any state.

The reference clock rate is a parameter (3 579 545 Hz by default), and every count is in cycles of that clock.

Top module: `dtmf_freq_detector`

## Requirements
- R1: A period is the number of clock cycles between two successive rising edges of a band input. A tone is judged on the sum of the last four consecutive periods, not on any single period. Alternating periods that lie outside the tone window individually are accepted when their mean lies inside it. Alternating periods whose mean lies outside the window are rejected even if half of them are exactly nominal.
- R2: A period shorter than 0.9 times the shortest nominal period of its band, or longer than 1.1 times the longest, empties the window. After such a period, early_valid stays low until four new in-range periods have been seen. An extra edge inside a locked tone therefore drops early_valid, and early_valid returns after the tone continues cleanly.
- R3: A tone whose frequency is within ±(1.5 % + 2 Hz) of nominal is accepted. Each tone window is the nominal period ±2.5 %, and at most one tone per band matches at a time.
- R4: A tone that deviates by 3.5 % or more from nominal is never reported: early_valid stays low.
- R5: All 16 pairs decode. row_idx is 0, 1, 2, 3 for 697, 770, 852, 941 Hz. col_idx is 0, 1, 2, 3 for 1209, 1336, 1477, 1633 Hz.
- R6: If either input stops toggling, early_valid falls no later than 1.1 times the band's longest nominal period plus 8 cycles after that input's last rising edge. The flag is not latched: it rises again once the tone resumes.
- R7: While pdn is high, both trackers are held in TRK_IDLE and early_valid is low from the first clock edge after pdn rises. After pdn falls, each band needs a first edge and then four fresh periods before early_valid can rise.
- R8: After reset, and whenever early_valid is low, early_valid, row_idx and col_idx are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all period counts are in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| pdn | input | 1 | Power-down; holds both trackers idle and forces early_valid low |
| lo_sq | input | 1 | Limited square wave of the low band (asynchronous) |
| hi_sq | input | 1 | Limited square wave of the high band (asynchronous) |
| early_valid | output | 1 | High while one low tone and one high tone both match |
| row_idx | output | 2 | Low-band tone index, 0 when early_valid is low |
| col_idx | output | 2 | High-band tone index, 0 when early_valid is low |

## Verification
The bench goes after the tolerance edges in both directions on every tone: ±(1.5 % + 2 Hz) must be accepted and ±3.5 % rejected. A window that is too narrow loses genuine digits, and one that is too wide lets 3.5 % deviants through or matches a neighbouring tone. It feeds alternating periods to separate averaging from single-period matching, and injects an extra edge into a locked tone to confirm that the window is emptied. It stops each band in turn, and holds and then releases power-down. A tracker that missed the quiet timeout, or that kept stale periods across power-down, would hold early_valid high or let it return too early.

// File: rtl/dtd_pkg.sv
package dtd_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_FILL = 2'd1,
        TRK_LOCK = 2'd2
    } trk_state_e;

    localparam int unsigned TONES_PER_GRP = 4;

    // Nominal tone frequency in Hz; grp 0 = low band, 1 = high band
    function automatic int unsigned tone_hz(input int unsigned grp, input int unsigned idx);
        int unsigned hz;
        if (grp == 0) begin
            case (idx)
                0:       hz = 697;
                1:       hz = 770;
                2:       hz = 852;
                default: hz = 941;
            endcase
        end else begin
            case (idx)
                0:       hz = 1209;
                1:       hz = 1336;
                2:       hz = 1477;
                default: hz = 1633;
            endcase
        end
        return hz;
    endfunction

    // Rounded nominal period in reference-clock cycles
    function automatic int unsigned nom_period(input int unsigned clk_hz,
                                               input int unsigned grp,
                                               input int unsigned idx);
        int unsigned hz;
        hz = tone_hz(grp, idx);
        return (clk_hz + hz / 2) / hz;
    endfunction

    // v scaled by pm per mille, truncated
    function automatic int unsigned scale_pm(input int unsigned v, input int unsigned pm);
        return (v * pm) / 1000;
    endfunction
endpackage

// File: rtl/dtd_period_meter.sv
module dtd_period_meter #(
    parameter int unsigned CW      = 14,
    parameter int unsigned CNT_MAX = 5000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pdn,
    input  logic          sq_in,
    output logic          edge_o,
    output logic [CW-1:0] per_o,
    output logic          stale_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [2:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // two-flop synchroniser plus one stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], sq_in};
    end

    assign edge_o = sync_q[1] & ~sync_q[2];

    // cycles since last rising edge, saturating one past the coarse limit
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (pdn || edge_o)            cnt_q <= '0;
        else if (cnt_q != CW'(CNT_MAX))    cnt_q <= cnt_q + CW'(1);
    end

    assign per_o   = cnt_q + CW'(1);
    assign stale_o = (cnt_q == CW'(CNT_MAX));

    // R6: the quiet timer never wraps, so a silent input always stays stale
    p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(CNT_MAX));

    // R6: the counter restarts after every rising edge
    p_edge_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o && !pdn) |=> (cnt_q == '0));
endmodule

// File: rtl/dtd_tone_matcher.sv
module dtd_tone_matcher #(
    parameter int unsigned GRP    = 0,
    parameter int unsigned CLK_HZ = 3579545,
    parameter int unsigned NAVG   = 4,
    parameter int unsigned TOL_PM = 25,
    parameter int unsigned SW     = 16
) (
    input  logic [SW-1:0]                      sum_i,
    output logic [dtd_pkg::TONES_PER_GRP-1:0]  hit_o
);
    timeunit 1ns;
    timeprecision 1ps;

    for (genvar t = 0; t < dtd_pkg::TONES_PER_GRP; t++) begin : g_tone
        localparam int unsigned P    = dtd_pkg::nom_period(CLK_HZ, GRP, t);
        localparam int unsigned D    = dtd_pkg::scale_pm(P, TOL_PM);
        localparam int unsigned S_LO = NAVG * (P - D);
        localparam int unsigned S_HI = NAVG * (P + D);
        assign hit_o[t] = (sum_i >= SW'(S_LO)) && (sum_i <= SW'(S_HI));
    end
endmodule

// File: rtl/dtd_tone_tracker.sv
module dtd_tone_tracker #(
    parameter int unsigned GRP       = 0,
    parameter int unsigned CLK_HZ    = 3579545,
    parameter int unsigned NAVG      = 4,
    parameter int unsigned TOL_PM    = 25,
    parameter int unsigned COARSE_PM = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdn,
    input  logic       sq_in,
    output logic       tone_ok,
    output logic [1:0] tone_idx
);
    timeunit 1ns;
    timeprecision 1ps;
    import dtd_pkg::*;

    localparam int unsigned NT      = TONES_PER_GRP;
    localparam int unsigned P_SHORT = nom_period(CLK_HZ, GRP, NT - 1);
    localparam int unsigned P_LONG  = nom_period(CLK_HZ, GRP, 0);
    localparam int unsigned CMIN    = scale_pm(P_SHORT, 1000 - COARSE_PM);
    localparam int unsigned CMAX    = scale_pm(P_LONG, 1000 + COARSE_PM);
    localparam int unsigned CNT_MAX = CMAX + 1;
    localparam int unsigned CW      = $clog2(CNT_MAX + 2) + 1;
    localparam int unsigned AW      = $clog2(NAVG);
    localparam int unsigned SW      = CW + AW;

    logic          edge_w, stale_w;
    logic [CW-1:0] per_w;
    logic [NT-1:0] hit_w;

    trk_state_e    state_q, state_d;
    logic [AW-1:0] fill_q, fill_d;
    logic          push, clear;
    logic [CW-1:0] hist_q [NAVG];
    logic [SW-1:0] sum_q;
    logic          in_range;

    dtd_period_meter #(.CW(CW), .CNT_MAX(CNT_MAX)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .pdn     (pdn),
        .sq_in   (sq_in),
        .edge_o  (edge_w),
        .per_o   (per_w),
        .stale_o (stale_w)
    );

    dtd_tone_matcher #(
        .GRP(GRP), .CLK_HZ(CLK_HZ), .NAVG(NAVG), .TOL_PM(TOL_PM), .SW(SW)
    ) u_match (
        .sum_i (sum_q),
        .hit_o (hit_w)
    );

    assign in_range = (per_w >= CW'(CMIN)) && (per_w <= CW'(CMAX));

    // next-state and window control
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        push    = 1'b0;
        clear   = 1'b0;
        unique case (state_q)
            TRK_IDLE: begin
                if (edge_w) begin
                    state_d = TRK_FILL;
                    fill_d  = '0;
                    clear   = 1'b1;
                end
            end
            TRK_FILL: begin
                if (stale_w) begin
                    state_d = TRK_IDLE;
                    clear   = 1'b1;
                end else if (edge_w) begin
                    if (in_range) begin
                        push = 1'b1;
                        if (fill_q == AW'(NAVG - 1)) state_d = TRK_LOCK;
                        else                         fill_d  = fill_q + AW'(1);
                    end else begin
                        fill_d = '0;
                        clear  = 1'b1;
                    end
                end
            end
            TRK_LOCK: begin
                if (stale_w) begin
                    state_d = TRK_IDLE;
                    clear   = 1'b1;
                end else if (edge_w) begin
                    if (in_range) begin
                        push = 1'b1;
                    end else begin
                        state_d = TRK_FILL;
                        fill_d  = '0;
                        clear   = 1'b1;
                    end
                end
            end
            default: begin
                state_d = TRK_IDLE;
                clear   = 1'b1;
            end
        endcase
        if (pdn) begin
            state_d = TRK_IDLE;
            fill_d  = '0;
            push    = 1'b0;
            clear   = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
        end
    end

    // sliding window of the last NAVG periods and their running sum
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int i = 0; i < NAVG; i++) hist_q[i] <= '0;
            sum_q <= '0;
        end else if (push) begin
            hist_q[0] <= per_w;
            for (int i = 1; i < NAVG; i++) hist_q[i] <= hist_q[i-1];
            sum_q <= sum_q - SW'(hist_q[NAVG-1]) + SW'(per_w);
        end
    end

    // outputs
    always_comb begin
        tone_ok  = (state_q == TRK_LOCK) && (|hit_w);
        tone_idx = '0;
        for (int t = NT - 1; t >= 0; t--) begin
            if (hit_w[t]) tone_idx = 2'(t);
        end
    end

    // R3: tone windows of one band never overlap
    p_hit_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_w));

    // R6: a quiet input sends an active tracker back to idle
    p_stale_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stale_w && !pdn && state_q != TRK_IDLE) |=> (state_q == TRK_IDLE));

    // R2: lock is only ever reached from a filling window
    p_lock_from_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == TRK_LOCK) |-> ($past(state_q) == TRK_FILL));

    // R7: power-down parks the tracker
    p_pdn_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |=> (state_q == TRK_IDLE));
endmodule

// File: rtl/dtmf_freq_detector.sv
module dtmf_freq_detector #(
    parameter int unsigned CLK_HZ    = 3579545,
    parameter int unsigned NAVG      = 4,
    parameter int unsigned TOL_PM    = 25,
    parameter int unsigned COARSE_PM = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdn,
    input  logic       lo_sq,
    input  logic       hi_sq,
    output logic       early_valid,
    output logic [1:0] row_idx,
    output logic [1:0] col_idx
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned NGRP = 2;

    logic [NGRP-1:0]   sq_w;
    logic [NGRP-1:0]   ok_w;
    logic [2*NGRP-1:0] idx_w;
    logic              pair_ok;

    assign sq_w = {hi_sq, lo_sq};

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        dtd_tone_tracker #(
            .GRP(g), .CLK_HZ(CLK_HZ), .NAVG(NAVG),
            .TOL_PM(TOL_PM), .COARSE_PM(COARSE_PM)
        ) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .pdn      (pdn),
            .sq_in    (sq_w[g]),
            .tone_ok  (ok_w[g]),
            .tone_idx (idx_w[2*g +: 2])
        );
    end

    assign pair_ok = (&ok_w) && !pdn;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early_valid <= 1'b0;
            row_idx     <= '0;
            col_idx     <= '0;
        end else begin
            early_valid <= pair_ok;
            row_idx     <= pair_ok ? idx_w[1:0] : 2'b00;
            col_idx     <= pair_ok ? idx_w[3:2] : 2'b00;
        end
    end

    // R7: power-down clears the flag on the next edge
    p_pdn_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |=> !early_valid);

    // R5: the flag only follows a cycle in which both bands matched
    p_valid_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        early_valid |-> $past(&ok_w));
endmodule

// File: tb/sim_dtmf_freq_detector.sv
module sim_dtmf_freq_detector;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned B_CLK  = 200000;
    localparam int          SETTLE = 1700;
    localparam int          WIN    = 400;
    localparam int          WDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pdn = 1'b0;
    logic       lo_sq = 1'b0;
    logic       hi_sq = 1'b0;
    logic       early_valid;
    logic [1:0] row_idx, col_idx;

    int n_chk = 0;
    int n_err = 0;
    bit ended = 0;

    int lo_pa = 0, lo_pb = 0, hi_pa = 0, hi_pb = 0;
    bit hi_glitch = 0;

    real lo_hz [4] = '{697.0, 770.0, 852.0, 941.0};
    real hi_hz [4] = '{1209.0, 1336.0, 1477.0, 1633.0};

    always #4 clk = ~clk;

    dtmf_freq_detector #(.CLK_HZ(B_CLK)) u0 (
        .clk(clk), .rst_n(rst_n), .pdn(pdn), .lo_sq(lo_sq), .hi_sq(hi_sq),
        .early_valid(early_valid), .row_idx(row_idx), .col_idx(col_idx)
    );

    function automatic int cyc_of(real f);
        return $rtoi(real'(B_CLK) / f + 0.5);
    endfunction

    // low band generator: alternates between two periods (equal for a pure tone)
    initial begin : gen_lo
        bit alt;
        alt = 0;
        forever begin
            if (lo_pa == 0) begin
                lo_sq = 0;
                @(negedge clk);
            end else begin
                int p;
                p = alt ? lo_pb : lo_pa;
                alt = ~alt;
                lo_sq = 1; repeat (p / 2) @(negedge clk);
                lo_sq = 0; repeat (p - p / 2) @(negedge clk);
            end
        end
    end

    // high band generator with optional one-shot extra edge
    initial begin : gen_hi
        bit alt;
        alt = 0;
        forever begin
            if (hi_pa == 0) begin
                hi_sq = 0;
                @(negedge clk);
            end else begin
                int p;
                p = alt ? hi_pb : hi_pa;
                alt = ~alt;
                if (hi_glitch) begin
                    hi_glitch = 0;
                    hi_sq = 1; repeat (p / 4) @(negedge clk);
                    hi_sq = 0; repeat (2) @(negedge clk);
                    hi_sq = 1; repeat (p / 2 - p / 4 - 2) @(negedge clk);
                end else begin
                    hi_sq = 1; repeat (p / 2) @(negedge clk);
                end
                hi_sq = 0; repeat (p - p / 2) @(negedge clk);
            end
        end
    end

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // values are shown as valid*100 + row*10 + col
    task automatic watch(int n, bit ev_exp, int r, int c, string req, string what);
        bit bad;
        int act;
        bad = 0;
        act = ev_exp * 100 + r * 10 + c;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (early_valid !== ev_exp ||
                (ev_exp ? (row_idx !== 2'(r) || col_idx !== 2'(c))
                        : (row_idx !== 2'b00 || col_idx !== 2'b00))) begin
                if (!bad) act = int'(early_valid) * 100 + int'(row_idx) * 10 + int'(col_idx);
                bad = 1;
            end
        end
        check(!bad, req, what, act, ev_exp ? (100 + r * 10 + c) : 0);
    endtask

    task automatic tones(int lp, int hp);
        lo_pa = lp; lo_pb = lp; hi_pa = hp; hi_pb = hp;
    endtask

    initial begin : watchdog
        repeat (WDOG) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
        summary();
    end

    initial begin : main
        repeat (10) @(negedge clk);
        // R8: reset state
        check(early_valid === 1'b0 && row_idx === 2'b00 && col_idx === 2'b00,
              "R8", "reset outputs", int'(early_valid) * 100 + int'(row_idx) * 10 + int'(col_idx), 0);
        rst_n = 1;
        watch(200, 0, 0, 0, "R8", "silent inputs after reset");

        // R5: every row/column pair at nominal frequency
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                tones(cyc_of(lo_hz[r]), cyc_of(hi_hz[c]));
                repeat (SETTLE) @(negedge clk);
                watch(WIN, 1, r, c, "R5", "nominal pair");
            end
        end

        // R3 / R4: tolerance edges on every tone, partner at nominal
        for (int g = 0; g < 2; g++) begin
            for (int t = 0; t < 4; t++) begin
                for (int k = 0; k < 4; k++) begin
                    real f0;
                    real f;
                    bit acc;
                    f0 = (g == 0) ? lo_hz[t] : hi_hz[t];
                    case (k)
                        0:       f = f0 * 1.015 + 2.0;
                        1:       f = f0 * 0.985 - 2.0;
                        2:       f = f0 * 1.035;
                        default: f = f0 * 0.965;
                    endcase
                    acc = (k < 2);
                    if (g == 0) tones(cyc_of(f), cyc_of(hi_hz[t]));
                    else        tones(cyc_of(lo_hz[t]), cyc_of(f));
                    repeat (SETTLE) @(negedge clk);
                    if (acc) watch(WIN, 1, t, t, "R3", "accept edge deviation");
                    else     watch(WIN, 0, 0, 0, "R4", "reject deviation");
                end
            end
        end

        // R1: alternating periods, each outside the window, mean nominal (165)
        lo_pa = cyc_of(lo_hz[0]); lo_pb = lo_pa;
        hi_pa = 158; hi_pb = 172;
        repeat (SETTLE) @(negedge clk);
        watch(WIN, 1, 0, 0, "R1", "mean of alternating periods inside window");
        // R1: half the periods nominal, mean 170.5 outside window
        hi_pa = 165; hi_pb = 176;
        repeat (SETTLE) @(negedge clk);
        watch(WIN, 0, 0, 0, "R1", "mean outside window");

        // R2: extra edge in a locked tone empties the window
        tones(cyc_of(lo_hz[1]), cyc_of(hi_hz[2]));
        repeat (SETTLE) @(negedge clk);
        watch(WIN, 1, 1, 2, "R2", "locked before glitch");
        hi_glitch = 1;
        begin
            bit saw_low;
            saw_low = 0;
            for (int i = 0; i < 400; i++) begin
                @(negedge clk);
                if (early_valid === 1'b0) saw_low = 1;
            end
            check(saw_low, "R2", "extra edge drops flag", 1, 0);
        end
        repeat (SETTLE) @(negedge clk);
        watch(WIN, 1, 1, 2, "R2", "recovery after glitch");

        // R6: low band stops, then resumes
        lo_pa = 0; lo_pb = 0;
        repeat (330) @(negedge clk);
        watch(300, 0, 0, 0, "R6", "low band silent");
        lo_pa = cyc_of(lo_hz[2]); lo_pb = lo_pa;
        repeat (SETTLE) @(negedge clk);
        watch(WIN, 1, 2, 2, "R6", "low band resumed");
        // R6: high band stops, then resumes
        hi_pa = 0; hi_pb = 0;
        repeat (200) @(negedge clk);
        watch(300, 0, 0, 0, "R6", "high band silent");
        hi_pa = cyc_of(hi_hz[0]); hi_pb = hi_pa;
        repeat (SETTLE) @(negedge clk);
        watch(WIN, 1, 2, 0, "R6", "high band resumed");

        // R7: power-down
        tones(cyc_of(lo_hz[3]), cyc_of(hi_hz[3]));
        repeat (SETTLE) @(negedge clk);
        watch(WIN, 1, 3, 3, "R7", "locked before power-down");
        pdn = 1;
        @(negedge clk);
        check(early_valid === 1'b0, "R7", "flag low one edge after pdn", int'(early_valid), 0);
        watch(1000, 0, 0, 0, "R7", "held low during power-down");
        pdn = 0;
        watch(800, 0, 0, 0, "R7", "no early return after release");
        repeat (SETTLE) @(negedge clk);
        watch(WIN, 1, 3, 3, "R7", "reacquired after release");

        summary();
    end
endmodule